// File: doc/BRIEF.md
# Pipelined Burst Static Memory Front End

This block is a clocked static memory with a registered address, control and write-data path and a pipelined read path. An access begins when one of two address strobes is low at a clock edge. The processor strobe always opens a read. The controller strobe can open a read or a write in the same cycle. Three chip enables decide whether a start selects the device. Once selected, the device runs a burst. On each later edge with no start, the advance input either steps the low address bits or holds them, so wait states can be inserted. Every cycle of the burst is a read or a write, depending on the write enables at that edge.

Write qualification works per byte lane. It uses a global write enable, a byte-write enable and one enable per lane. Read data leaves through a registered output stage and appears one clock after the edge that presented the address. An asynchronous output enable blanks it. A sleep input puts the device into power-down and keeps the stored words. After sleep is released there is a fixed lockout window. Strobes during that window are ignored and raise a sticky violation flag. The data bus is split into separate input, output and output-valid ports.

Top module: `sbsram_core`

## Requirements
- R1: Write lanes are chosen as follows. With `gw_n` low, all lanes are written. Otherwise, with `bwe_n` low, lane n is written where `bw_n[n]` is low. Lane n covers data bits 8n to 8n+7.
- R2: A cycle with no lane enabled is a read. This is the case when `gw_n` and `bwe_n` are both high, or when `gw_n` is high and every `bw_n` bit is high. Such a cycle leaves memory unchanged and, at a start, returns the addressed word.
- R3: A start on `strb_cpu_n` (low, with `ce1_n` low) is always a read, even with write enables asserted. A write through this path is made on the next edge as a burst cycle with `adv_n` high, to the same address.
- R4: A start on `strb_ctl_n` with write enables asserted writes the addressed word in that same cycle. It produces no read output.
- R5: With `ce1_n` high, `strb_cpu_n` is ignored and the edge acts as a burst cycle. `strb_ctl_n` low with `ce1_n` high deselects the device.
- R6: `ce2` low or `ce3_n` high at a start deselects the device. No access is made, and later burst cycles do nothing until a new start. On burst cycles, `ce2` and `ce3_n` are not looked at.
- R7: On a burst cycle, `adv_n` low sets the two low address bits to their value plus one, modulo 4, with the upper bits unchanged. `adv_n` high repeats the current address.
- R8: For a read whose address is taken at edge k, `rvalid` and `rdata` show the word after edge k+1, and not after edge k.
- R9: `oe_n` high forces `rvalid` low and `rdata` to zero at once, without waiting for a clock edge. `oe_n` low restores the pending word.
- R10: At an edge with `sleep` high, no access is made and the device is deselected. After the following edge `rvalid` is low. Stored words are kept.
- R11: During the first 2 edges with `sleep` low after power-down, strobes start nothing. If either strobe is low on such an edge, `viol` rises and stays high until reset.
- R12: Reset (synchronous, active high) leaves `rvalid` and `viol` low and the device deselected, so burst cycles produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW | Word address taken at a start |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | DW/8 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid and output enabled |
| viol | output | 1 | Sticky wake-lockout violation |

## Verification
The properties assume that `ce2`, `ce3_n` and the strobes are stable across each edge. They also assume that `sleep` is a level held for whole cycles. They do not rely on the strobe discipline after wake, because the violation path itself is checked.

The stimulus changes every input one time unit after a rising edge. It never presents a read of a word that has not been written. It covers the whole address space with bursts from every starting offset, so the modulo-4 wrap occurs on every aligned group.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_DOWN = 2'd1,
        PWR_WAKE = 2'd2
    } pwr_e;

    typedef enum logic [1:0] {
        CYC_NONE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_CPU   = 2'd1,
        SRC_CTL   = 2'd2,
        SRC_BURST = 2'd3
    } src_e;

    typedef struct packed {
        src_e src;
        logic chip_ok;
        logic wr_req;
    } dec_t;

endpackage

// File: rtl/sbr_power.sv
module sbr_power
    import sbr_pkg::*;
#(
    parameter int WAKE_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep,
    input  logic any_strobe,
    output logic lock,
    output logic run_ok,
    output logic viol
);
    localparam int CW = $clog2(WAKE_CYC + 1);

    pwr_e          pwr_q;
    logic [CW-1:0] cnt_q;

    assign run_ok = (pwr_q == PWR_RUN);
    assign lock   = sleep || !run_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q <= PWR_RUN;
            cnt_q <= '0;
        end else begin
            case (pwr_q)
                PWR_RUN: begin
                    if (sleep) pwr_q <= PWR_DOWN;
                end
                PWR_DOWN: begin
                    if (!sleep) begin
                        if (WAKE_CYC > 1) begin
                            pwr_q <= PWR_WAKE;
                            cnt_q <= CW'(WAKE_CYC - 1);
                        end else begin
                            pwr_q <= PWR_RUN;
                        end
                    end
                end
                PWR_WAKE: begin
                    if (sleep) begin
                        pwr_q <= PWR_DOWN;
                    end else if (cnt_q <= CW'(1)) begin
                        pwr_q <= PWR_RUN;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                default: pwr_q <= PWR_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol <= 1'b0;
        end else if (!sleep && !run_ok && any_strobe) begin
            viol <= 1'b1;
        end
    end

endmodule

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
    import sbr_pkg::*;
#(
    parameter int AW      = 6,
    parameter int DW      = 32,
    parameter int BURST_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock,
    input  logic [AW-1:0]    addr,
    input  logic             strb_cpu_n,
    input  logic             strb_ctl_n,
    input  logic             adv_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [DW/8-1:0]  bw_n,
    input  logic [DW-1:0]    wdata,
    output cyc_e             op_kind,
    output logic [AW-1:0]    op_addr,
    output logic [DW/8-1:0]  op_be,
    output logic [DW-1:0]    op_data
);
    localparam int NB = DW / LANE_W;

    logic          sel_q;
    logic [AW-1:0] cur_q;
    logic [AW-1:0] nxt_addr;
    logic [NB-1:0] lanes;
    dec_t          dec;

    // lane qualification: global write overrides, else byte-write gated lanes
    always_comb begin
        if (!gw_n)       lanes = '1;
        else if (!bwe_n) lanes = ~bw_n;
        else             lanes = '0;
    end

    // linear step of the low burst bits, upper bits held
    generate
        if (BURST_W >= AW) begin : g_full_wrap
            assign nxt_addr = adv_n ? cur_q : cur_q + AW'(1);
        end else begin : g_low_wrap
            logic [BURST_W-1:0] low_inc;
            assign low_inc  = cur_q[BURST_W-1:0] + BURST_W'(1);
            assign nxt_addr = adv_n ? cur_q : {cur_q[AW-1:BURST_W], low_inc};
        end
    endgenerate

    always_comb begin
        dec.wr_req  = |lanes;
        dec.chip_ok = !ce1_n && ce2 && !ce3_n;
        if (lock)                        dec.src = SRC_NONE;
        else if (!strb_cpu_n && !ce1_n)  dec.src = SRC_CPU;
        else if (!strb_ctl_n)            dec.src = SRC_CTL;
        else if (sel_q)                  dec.src = SRC_BURST;
        else                             dec.src = SRC_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= 1'b0;
            cur_q   <= '0;
            op_kind <= CYC_NONE;
        end else begin
            op_kind <= CYC_NONE;
            case (dec.src)
                SRC_CPU, SRC_CTL: begin
                    sel_q <= dec.chip_ok;
                    if (dec.chip_ok) begin
                        cur_q   <= addr;
                        op_kind <= (dec.src == SRC_CTL && dec.wr_req) ? CYC_WRITE : CYC_READ;
                    end
                end
                SRC_BURST: begin
                    cur_q   <= nxt_addr;
                    op_kind <= dec.wr_req ? CYC_WRITE : CYC_READ;
                end
                default: begin
                    if (lock) sel_q <= 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        op_addr <= (dec.src == SRC_BURST) ? nxt_addr : addr;
        op_be   <= (dec.src == SRC_CPU) ? '0 : lanes;
        op_data <= wdata;
    end

endmodule

// File: rtl/sbr_array.sv
module sbr_array
    import sbr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  cyc_e                     op_kind,
    input  logic [$clog2(DEPTH)-1:0] op_addr,
    input  logic [DW/8-1:0]          op_be,
    input  logic [DW-1:0]            op_data,
    output logic [DW-1:0]            dout,
    output logic                     dvld
);
    localparam int NB = DW / LANE_W;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (op_kind == CYC_WRITE) begin
            for (int l = 0; l < NB; l++) begin
                if (op_be[l]) mem[op_addr][l*LANE_W +: LANE_W] <= op_data[l*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (op_kind == CYC_READ) dout <= mem[op_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) dvld <= 1'b0;
        else     dvld <= (op_kind == CYC_READ);
    end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
    import sbr_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int DW       = 32,
    parameter int BURST_W  = 2,
    parameter int WAKE_CYC = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic                     strb_cpu_n,
    input  logic                     strb_ctl_n,
    input  logic                     adv_n,
    input  logic                     ce1_n,
    input  logic                     ce2,
    input  logic                     ce3_n,
    input  logic                     gw_n,
    input  logic                     bwe_n,
    input  logic [DW/8-1:0]          bw_n,
    input  logic                     oe_n,
    input  logic                     sleep,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata,
    output logic                     rvalid,
    output logic                     viol
);
    localparam int AW = $clog2(DEPTH);

    logic          lock;
    logic          run_ok;
    logic          rd_vld;
    logic [DW-1:0] rd_word;
    cyc_e          op_kind;
    logic [AW-1:0] op_addr;
    logic [DW/8-1:0] op_be;
    logic [DW-1:0] op_data;

    sbr_power #(.WAKE_CYC(WAKE_CYC)) u_pwr (
        .clk        (clk),
        .rst        (rst),
        .sleep      (sleep),
        .any_strobe (!strb_cpu_n || !strb_ctl_n),
        .lock       (lock),
        .run_ok     (run_ok),
        .viol       (viol)
    );

    sbr_ctrl #(.AW(AW), .DW(DW), .BURST_W(BURST_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .lock       (lock),
        .addr       (addr),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .adv_n      (adv_n),
        .ce1_n      (ce1_n),
        .ce2        (ce2),
        .ce3_n      (ce3_n),
        .gw_n       (gw_n),
        .bwe_n      (bwe_n),
        .bw_n       (bw_n),
        .wdata      (wdata),
        .op_kind    (op_kind),
        .op_addr    (op_addr),
        .op_be      (op_be),
        .op_data    (op_data)
    );

    sbr_array #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .op_kind (op_kind),
        .op_addr (op_addr),
        .op_be   (op_be),
        .op_data (op_data),
        .dout    (rd_word),
        .dvld    (rd_vld)
    );

    assign rvalid = rd_vld && !oe_n;
    assign rdata  = rvalid ? rd_word : '0;

endmodule

// File: rtl/sbr_chk.sv
module sbr_chk (
    input logic clk,
    input logic rst,
    input logic strb_cpu_n,
    input logic strb_ctl_n,
    input logic ce1_n,
    input logic ce2,
    input logic ce3_n,
    input logic gw_n,
    input logic oe_n,
    input logic sleep,
    input logic rvalid,
    input logic viol,
    input logic run_ok,
    input logic rd_vld
);
    AST_OE_BLANKS: assert property (@(posedge clk) disable iff (rst) oe_n |-> !rvalid); // R9

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst) $past(sleep) |=> !rd_vld); // R10

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst) viol |=> viol); // R11

    AST_VIOL_RAISE: assert property (@(posedge clk) disable iff (rst)
        (!run_ok && !sleep && !strb_ctl_n) |=> viol); // R11

    AST_CE1_DESELECT: assert property (@(posedge clk) disable iff (rst)
        (!strb_ctl_n && ce1_n) |=> ##1 !rd_vld); // R5

    AST_CTL_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!strb_ctl_n && strb_cpu_n && !ce1_n && ce2 && !ce3_n && !gw_n) |=> ##1 !rd_vld); // R4

    AST_CPU_READS: assert property (@(posedge clk) disable iff (rst)
        (run_ok && !sleep && !strb_cpu_n && !ce1_n && ce2 && !ce3_n) |=> ##1 rd_vld); // R3

endmodule

bind sbsram_core sbr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .gw_n       (gw_n),
    .oe_n       (oe_n),
    .sleep      (sleep),
    .rvalid     (rvalid),
    .viol       (viol),
    .run_ok     (run_ok),
    .rd_vld     (rd_vld)
);

// File: tb/sim_sbsram_core.sv
module sim_sbsram_core;
    localparam int DEPTH = 64;
    localparam int DW    = 32;
    localparam int AW    = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst, strb_cpu_n, strb_ctl_n, adv_n, ce1_n, ce2, ce3_n;
    logic          gw_n, bwe_n, oe_n, sleep;
    logic [3:0]    bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic          rvalid, viol;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [DW-1:0] ref_m [DEPTH];

    sbsram_core u0 (
        .clk(clk), .rst(rst), .addr(addr), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .oe_n(oe_n), .sleep(sleep), .wdata(wdata), .rdata(rdata),
        .rvalid(rvalid), .viol(viol)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
        ce1_n = 0; ce2 = 1; ce3_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = 4'hF;
        addr = '0; wdata = '0;
    endtask

    function automatic logic [AW-1:0] bnext(input logic [AW-1:0] a, input int i);
        return {a[AW-1:2], 2'(int'(a[1:0]) + i)};
    endfunction

    function automatic logic [DW-1:0] pat(input int a);
        return (32'(a) * 32'h0101_0101) ^ 32'h3C5A_96E1;
    endfunction

    task automatic ctl_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic g, input logic be, input logic [3:0] bw);
        logic [3:0] m;
        idle();
        strb_ctl_n = 0; addr = a; wdata = d; gw_n = g; bwe_n = be; bw_n = bw;
        tick();
        idle();
        m = !g ? 4'hF : (!be ? ~bw : 4'h0);
        for (int l = 0; l < 4; l++) if (m[l]) ref_m[a][l*8 +: 8] = d[l*8 +: 8];
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input string req);
        idle();
        strb_ctl_n = 0; addr = a;
        tick();
        idle();
        tick();
        #2;
        chk(rvalid === 1'b1 && rdata === ref_m[a], req, rdata, ref_m[a]);
    endtask

    task automatic burst_chk(input logic [AW-1:0] a, input string req);
        idle();
        strb_ctl_n = 0; addr = a;
        tick();
        for (int i = 0; i < 4; i++) begin
            idle();
            adv_n = (i < 3) ? 1'b0 : 1'b1;
            tick();
            #2;
            chk(rvalid === 1'b1 && rdata === ref_m[bnext(a, i)], req, rdata, ref_m[bnext(a, i)]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1; oe_n = 0; sleep = 0;
        repeat (3) tick();
        #2;
        chk(rvalid === 1'b0 && viol === 1'b0, "R12 reset state", {30'd0, rvalid, viol}, '0);
        rst = 0;
        tick();

        // fill every word with global write (R1)
        for (int a = 0; a < DEPTH; a++) ctl_wr(AW'(a), pat(a), 1'b0, 1'b1, 4'hF);
        tick();

        // bursts from every start offset (R7 wrap, R8 data timing)
        for (int a = 0; a < DEPTH; a++) burst_chk(AW'(a), "R7 linear burst");

        // R8: output appears after edge k+1, not after edge k
        idle(); strb_ctl_n = 0; ce1_n = 1; tick();
        idle(); tick(); tick();
        idle(); strb_ctl_n = 0; addr = 6'd3; tick();
        #2;
        chk(rvalid === 1'b0, "R8 not after first edge", {31'd0, rvalid}, '0);
        idle(); tick(); #2;
        chk(rvalid === 1'b1 && rdata === ref_m[3], "R8 after second edge", rdata, ref_m[3]);

        // R1: every lane mask through byte-write enable
        for (int m = 0; m < 16; m++) begin
            ctl_wr(6'd7, 32'h0, 1'b0, 1'b1, 4'hF);
            ctl_wr(6'd7, 32'hFFFF_FFFF, 1'b1, 1'b0, ~4'(m));
            rd_chk(6'd7, "R1 lane mask");
        end

        // R2: no lanes enabled leaves memory as is and reads
        ctl_wr(6'd9, 32'hDEAD_BEEF, 1'b1, 1'b1, 4'h0);
        tick(); #2;
        chk(rvalid === 1'b1 && rdata === ref_m[9], "R2 start reads", rdata, ref_m[9]);
        ctl_wr(6'd9, 32'hDEAD_BEEF, 1'b1, 1'b0, 4'hF);
        rd_chk(6'd9, "R2 unchanged");

        // R3: processor start reads, write lands on following edge
        idle(); strb_cpu_n = 0; addr = 6'd12; gw_n = 0; wdata = 32'h1234_5678; tick();
        idle(); gw_n = 0; wdata = 32'h1234_5678; tick(); #2;
        chk(rvalid === 1'b1 && rdata === ref_m[12], "R3 start is read", rdata, ref_m[12]);
        ref_m[12] = 32'h1234_5678;
        idle(); tick(); #2;
        chk(rvalid === 1'b0, "R3 follow-on write silent", {31'd0, rvalid}, '0);
        rd_chk(6'd12, "R3 written");

        // R4: controller start writes at once
        ctl_wr(6'd13, 32'hCAFE_F00D, 1'b0, 1'b1, 4'hF);
        tick(); #2;
        chk(rvalid === 1'b0, "R4 write silent", {31'd0, rvalid}, '0);
        rd_chk(6'd13, "R4 written");

        // R5: processor strobe with ce1 high acts as burst cycle
        idle(); strb_ctl_n = 0; addr = 6'd20; tick();
        idle(); strb_cpu_n = 0; ce1_n = 1; addr = 6'd40; adv_n = 0; tick(); #2;
        chk(rvalid === 1'b1 && rdata === ref_m[20], "R5 first", rdata, ref_m[20]);
        idle(); tick(); #2;
        chk(rvalid === 1'b1 && rdata === ref_m[21], "R5 cpu strobe ignored", rdata, ref_m[21]);
        idle(); strb_ctl_n = 0; ce1_n = 1; tick();
        idle(); adv_n = 0; tick(); tick(); #2;
        chk(rvalid === 1'b0, "R5 ctl with ce1 high deselects", {31'd0, rvalid}, '0);

        // R6: deselect by ce2 / ce3, and no effect on burst cycles
        idle(); strb_ctl_n = 0; ce2 = 0; gw_n = 0; addr = 6'd30; wdata = 32'h5555_AAAA; tick();
        idle(); adv_n = 0; tick(); tick(); #2;
        chk(rvalid === 1'b0, "R6 ce2 deselect", {31'd0, rvalid}, '0);
        rd_chk(6'd30, "R6 no write when deselected");
        idle(); strb_ctl_n = 0; ce3_n = 1; addr = 6'd31; tick();
        idle(); adv_n = 0; tick(); tick(); #2;
        chk(rvalid === 1'b0, "R6 ce3 deselect", {31'd0, rvalid}, '0);
        idle(); strb_ctl_n = 0; addr = 6'd33; tick();
        idle(); ce2 = 0; ce3_n = 1; adv_n = 0; tick(); #2;
        chk(rvalid === 1'b1 && rdata === ref_m[33], "R6 burst ignores ce2", rdata, ref_m[33]);
        idle(); ce2 = 0; ce3_n = 1; tick(); #2;
        chk(rvalid === 1'b1 && rdata === ref_m[34], "R6 burst ignores ce3", rdata, ref_m[34]);

        // R7: suspend repeats the address
        idle(); strb_ctl_n = 0; addr = 6'd45; tick();
        idle(); adv_n = 1; tick(); #2;
        chk(rdata === ref_m[45], "R7 suspend a", rdata, ref_m[45]);
        idle(); adv_n = 0; tick(); #2;
        chk(rdata === ref_m[45], "R7 suspend b", rdata, ref_m[45]);
        idle(); tick(); #2;
        chk(rdata === ref_m[46], "R7 resume", rdata, ref_m[46]);

        // R9: asynchronous output enable
        rd_chk(6'd50, "R9 setup");
        oe_n = 1; #1;
        chk(rvalid === 1'b0 && rdata === '0, "R9 blanked", rdata, '0);
        oe_n = 0; #1;
        chk(rvalid === 1'b1 && rdata === ref_m[50], "R9 restored", rdata, ref_m[50]);

        // R10 / R11: sleep, retention, wake lockout
        ctl_wr(6'd55, 32'h0BAD_CAFE, 1'b0, 1'b1, 4'hF);
        tick(); #2;
        chk(viol === 1'b0, "R11 clear before sleep", {31'd0, viol}, '0);
        idle(); sleep = 1; tick(); tick(); #2;
        chk(rvalid === 1'b0, "R10 quiet in sleep", {31'd0, rvalid}, '0);
        idle(); strb_ctl_n = 0; addr = 6'd55; tick();
        idle(); tick(); #2;
        chk(rvalid === 1'b0, "R10 strobe in sleep ignored", {31'd0, rvalid}, '0);
        idle(); sleep = 0; strb_ctl_n = 0; addr = 6'd55; tick(); #2;
        chk(viol === 1'b1, "R11 violation flagged", {31'd0, viol}, 32'd1);
        idle(); strb_ctl_n = 0; addr = 6'd55; tick(); #2;
        chk(rvalid === 1'b0, "R11 lockout edge 1", {31'd0, rvalid}, '0);
        idle(); tick(); #2;
        chk(rvalid === 1'b0, "R11 lockout edge 2", {31'd0, rvalid}, '0);
        rd_chk(6'd55, "R10 contents kept");
        chk(viol === 1'b1, "R11 sticky", {31'd0, viol}, 32'd1);

        // R12: mid-run reset
        rst = 1; tick(); tick(); #2;
        chk(viol === 1'b0 && rvalid === 1'b0, "R12 reset clears", {30'd0, rvalid, viol}, '0);
        rst = 0;
        idle(); adv_n = 0; tick(); tick(); #2;
        chk(rvalid === 1'b0, "R12 deselected after reset", {31'd0, rvalid}, '0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule